// File: doc/BRIEF.md
# Sector Read/Write Memory Queue

This block sits between a cache and the system bus. It accepts sector reads (line fills) and sector write-backs (evicted lines), holds them in two separate in-order queues, and moves each one across a request/grant bus as an eight-beat burst. The read queue holds two requests. The write queue holds three requests, and each of those entries carries a full eight-word sector. A completed read returns the whole sector to the cache side as one response.

Reads and writes that do not depend on each other are reordered. A pending read goes ahead of pending write-backs. The exception is a read whose sector address equals that of a queued write-back in the same ordering group. That read waits until such writes have left. Pulsing the barrier input closes the current ordering group. Nothing accepted later is placed on the bus until everything accepted earlier has finished its burst.

Top module: `sector_mem_queue`

## Requirements
- R1: After reset, `rd_ready`, `wr_ready` and `bar_ready` are 1, and `bus_req`, `bus_beat` and `rsp_valid` are 0.
- R2: An accepted read produces one burst with `bus_write`=0 and `bus_addr` set to its sector address. One cycle after the last beat, `rsp_valid` pulses for one cycle. At that point `rsp_addr` is the sector address and `rsp_data[32*i +: 32]` is the word received on beat i.
- R3: An accepted write-back produces one burst with `bus_write`=1, and beat i carries `wr_data[32*i +: 32]` on `bus_wdata`.
- R4: The read queue holds 2 requests and the write queue holds 3. A request stays counted until its burst ends. A full queue drives its ready low, and a valid offered while ready is low is dropped and never reaches the bus.
- R5: `bus_req` stays high with `bus_addr` and `bus_write` stable until `bus_gnt` is sampled high. In the next cycle `bus_beat` rises and stays high for exactly 8 consecutive cycles.
- R6: Within one ordering group, a waiting read is issued before any waiting write-back, provided that no write-back in that group has its sector address.
- R7: If a write-back in the read's group has the read's sector address, write-backs drain from the head of their queue until no such write remains, and then the read is issued.
- R8: Requests accepted before a barrier, or in the same cycle as it, all finish their bursts before any request accepted after it is issued.
- R9: `bar_ready` goes low when 7 barriers are outstanding, meaning groups are opened but older groups have not yet drained. It returns high once those groups drain.
- R10: Reads leave in the order they were accepted, and so do write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue has room |
| rd_addr | input | AW | Sector address of the read |
| wr_valid | input | 1 | Write-back offered |
| wr_ready | output | 1 | Write queue has room |
| wr_addr | input | AW | Sector address of the write-back |
| wr_data | input | 256 | Eight words, word i at bits 32*i+31:32*i |
| bar_valid | input | 1 | Ordering barrier |
| bar_ready | output | 1 | Barrier can be accepted |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_write | output | 1 | Current burst is a write |
| bus_addr | output | AW | Sector address of the current burst |
| bus_beat | output | 1 | A data beat is on the bus this cycle |
| bus_wdata | output | 32 | Write word for this beat |
| bus_rdata | input | 32 | Read word for this beat |
| rsp_valid | output | 1 | Read sector returned |
| rsp_addr | output | AW | Sector address of the returned read |
| rsp_data | output | 256 | Returned sector, word i at bits 32*i+31:32*i |

## Verification
The bench holds the grant low so that one read locks the engine, queues a mix of requests behind it, and then releases the grant. This shows the issue order directly. A design that served requests in arrival order fails the priority case. One that ignored address matches sends a read ahead of the write it depends on. One that ignored the barrier lets a younger read pass an older write-back. Filling both queues and offering one more request checks that the surplus never appears on the bus. Seven barriers behind a stalled request must drop `bar_ready`. Word order within every burst and response is compared against patterns keyed by address, which exposes a swapped or off-by-one beat index.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int WORD_W       = 32;
  localparam int SECTOR_WORDS = 8;
  localparam int SECTOR_W     = WORD_W * SECTOR_WORDS;
  localparam int BEAT_W       = $clog2(SECTOR_WORDS);

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [SECTOR_W-1:0] sector_t;
  typedef logic [BEAT_W-1:0]   beat_t;

  // word i of a sector lives at bits [WORD_W*i +: WORD_W]
  function automatic word_t sector_word(sector_t s, beat_t i);
    return s[int'(i)*WORD_W +: WORD_W];
  endfunction

  function automatic sector_t sector_put(sector_t s, beat_t i, word_t w);
    sector_t r;
    r = s;
    r[int'(i)*WORD_W +: WORD_W] = w;
    return r;
  endfunction
endpackage

// File: rtl/sq_fifo.sv
module sq_fifo #(
  parameter int W = 8,
  parameter int D = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   push_data,
  input  logic           pop,
  output logic           full,
  output logic [W-1:0]   head,
  output logic [D*W-1:0] slots,
  output logic [D-1:0]   live
);
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [CW-1:0] cnt;
  logic          do_pop;
  logic [CW-1:0] tail;

  assign full   = (cnt == CW'(D));
  assign do_pop = pop && (cnt != '0);
  assign tail   = cnt - CW'(do_pop);
  assign head   = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CW'(push) - CW'(do_pop);
  end

  // slot 0 is always the oldest; a pop shifts everything down by one
  always_ff @(posedge clk) begin
    for (int i = 0; i < D; i++) begin
      if (push && tail == CW'(i))  mem[i] <= push_data;
      else if (do_pop && i + 1 < D) mem[i] <= mem[(i + 1 < D) ? i + 1 : i];
    end
  end

  always_comb begin
    for (int i = 0; i < D; i++) begin
      slots[i*W +: W] = mem[i];
      live[i]         = (cnt > CW'(i));
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0);
endmodule

// File: rtl/sq_burst_engine.sv
module sq_burst_engine
  import sq_pkg::*;
#(
  parameter int AW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  sector_t       wdata,
  output logic          idle,
  output logic          done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_beat,
  output word_t         bus_wdata,
  input  word_t         bus_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output sector_t       rsp_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} state_t;

  state_t        st;
  beat_t         beat;
  logic          is_wr;
  logic [AW-1:0] addr;
  sector_t       rbuf;

  assign idle      = (st == ST_IDLE);
  assign bus_req   = (st == ST_REQ);
  assign bus_beat  = (st == ST_XFER);
  assign bus_write = is_wr;
  assign bus_addr  = addr;
  assign done      = bus_beat && (beat == BEAT_W'(SECTOR_WORDS - 1));
  assign bus_wdata = sector_word(wdata, beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      beat      <= '0;
      is_wr     <= 1'b0;
      addr      <= '0;
      rbuf      <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done && !is_wr;
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_REQ;
          is_wr <= start_wr;
          addr  <= start_addr;
        end
        ST_REQ: if (bus_gnt) begin
          st   <= ST_XFER;
          beat <= '0;
        end
        ST_XFER: begin
          beat <= beat + 1'b1;
          if (!is_wr) rbuf <= sector_put(rbuf, beat, bus_rdata);
          if (done) begin
            st <= ST_IDLE;
            if (!is_wr) begin
              rsp_addr <= addr;
              rsp_data <= sector_put(rbuf, beat, bus_rdata);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // run length of the current beat train, kept for the burst-length check
  logic [BEAT_W:0] beat_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        beat_run <= '0;
    else if (bus_beat) beat_run <= beat_run + 1'b1;
    else               beat_run <= '0;
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)));
  assert_beat_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> bus_beat);
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_beat && beat_run != '0) |-> beat_run == (BEAT_W+1)'(SECTOR_WORDS));
  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_beat && !bus_write));
endmodule

// File: rtl/sector_mem_queue.sv
module sector_mem_queue
  import sq_pkg::*;
#(
  parameter int AW       = 27,
  parameter int RD_DEPTH = 2,
  parameter int WR_DEPTH = 3,
  parameter int EW       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [AW-1:0]       rd_addr,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [SECTOR_W-1:0] wr_data,
  input  logic                bar_valid,
  output logic                bar_ready,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_write,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_beat,
  output logic [WORD_W-1:0]   bus_wdata,
  input  logic [WORD_W-1:0]   bus_rdata,
  output logic                rsp_valid,
  output logic [AW-1:0]       rsp_addr,
  output logic [SECTOR_W-1:0] rsp_data
);
  localparam int RPW = EW + AW;              // {group, addr}
  localparam int WPW = EW + AW + SECTOR_W;   // {group, addr, data}

  function automatic logic [EW-1:0] group_gap(logic [EW-1:0] newest, logic [EW-1:0] oldest);
    return newest - oldest;
  endfunction

  logic [EW-1:0] cur_grp, drain_grp;
  logic          rd_full, wr_full, rd_push, wr_push, bar_fire;
  logic          rd_pop, wr_pop;
  logic [RPW-1:0]          rd_head;
  logic [RD_DEPTH*RPW-1:0] rd_slots;
  logic [RD_DEPTH-1:0]     rd_live;
  logic [WPW-1:0]          wr_head;
  logic [WR_DEPTH*WPW-1:0] wr_slots;
  logic [WR_DEPTH-1:0]     wr_live;

  assign rd_ready  = !rd_full;
  assign wr_ready  = !wr_full;
  assign bar_ready = (group_gap(cur_grp, drain_grp) != '1);
  assign rd_push   = rd_valid && rd_ready;
  assign wr_push   = wr_valid && wr_ready;
  assign bar_fire  = bar_valid && bar_ready;

  sq_fifo #(.W(RPW), .D(RD_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_data({cur_grp, rd_addr}),
    .pop(rd_pop), .full(rd_full), .head(rd_head), .slots(rd_slots), .live(rd_live));

  sq_fifo #(.W(WPW), .D(WR_DEPTH)) u_wrq (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_data({cur_grp, wr_addr, wr_data}),
    .pop(wr_pop), .full(wr_full), .head(wr_head), .slots(wr_slots), .live(wr_live));

  logic [EW-1:0] rd_head_grp, wr_head_grp;
  logic [AW-1:0] rd_head_addr, wr_head_addr;
  assign rd_head_grp  = rd_head[AW +: EW];
  assign rd_head_addr = rd_head[AW-1:0];
  assign wr_head_grp  = wr_head[SECTOR_W+AW +: EW];
  assign wr_head_addr = wr_head[SECTOR_W +: AW];

  // events named for the assertions
  logic hazard, drain_busy, rd_elig, wr_elig, pick_rd, pick_wr;
  logic eng_idle, eng_done;

  always_comb begin
    hazard     = 1'b0;
    drain_busy = 1'b0;
    for (int j = 0; j < RD_DEPTH; j++)
      if (rd_live[j] && rd_slots[j*RPW+AW +: EW] == drain_grp) drain_busy = 1'b1;
    for (int j = 0; j < WR_DEPTH; j++)
      if (wr_live[j] && wr_slots[j*WPW+SECTOR_W+AW +: EW] == drain_grp) begin
        drain_busy = 1'b1;
        if (wr_slots[j*WPW+SECTOR_W +: AW] == rd_head_addr) hazard = 1'b1;
      end
  end

  assign rd_elig = rd_live[0] && (rd_head_grp == drain_grp);
  assign wr_elig = wr_live[0] && (wr_head_grp == drain_grp);
  assign pick_rd = eng_idle && rd_elig && !hazard;
  assign pick_wr = eng_idle && !pick_rd && wr_elig;
  assign rd_pop  = eng_done && !bus_write;
  assign wr_pop  = eng_done && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_grp   <= '0;
      drain_grp <= '0;
    end else begin
      if (bar_fire) cur_grp <= cur_grp + 1'b1;
      if (drain_grp != cur_grp && !drain_busy) drain_grp <= drain_grp + 1'b1;
    end
  end

  sq_burst_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(pick_rd || pick_wr), .start_wr(pick_wr),
    .start_addr(pick_wr ? wr_head_addr : rd_head_addr),
    .wdata(wr_head[SECTOR_W-1:0]),
    .idle(eng_idle), .done(eng_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_beat(bus_beat), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  assert_rd_pop_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> rd_head_grp == drain_grp);
  assert_wr_pop_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> wr_head_grp == drain_grp);
  assert_drain_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_grp != $past(drain_grp)) |-> $past(drain_grp != cur_grp));
  assert_wr_addr_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_write) |-> !(wr_live[0] && wr_head_grp == drain_grp && wr_head_addr == bus_addr
                                  && $past(!bus_req)));
endmodule

// File: tb/sector_mem_queue_test.sv
`timescale 1ns/1ps
module sector_mem_queue_test;
  localparam int AW = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic rd_valid = 0, wr_valid = 0, bar_valid = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [255:0] wr_data = '0;
  logic rd_ready, wr_ready, bar_ready;
  logic bus_req, bus_gnt, bus_write, bus_beat, rsp_valid;
  logic [AW-1:0] bus_addr, rsp_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [255:0] rsp_data;
  logic gnt_en = 1'b0;
  logic [2:0] bcnt;

  int checks = 0, errors = 0, bursts = 0, rsps = 0;
  logic [AW:0] expq[$];

  sector_mem_queue uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .bar_valid(bar_valid), .bar_ready(bar_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_beat(bus_beat), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  function automatic logic [31:0] wpat(logic [AW-1:0] a, int i);
    return {a[15:0] ^ 16'hA5A5, 8'(i), 8'h3C};
  endfunction
  function automatic logic [31:0] rpat(logic [AW-1:0] a, int i);
    return {a[23:0], 8'(i)} ^ 32'h5A00_0000;
  endfunction
  function automatic logic [255:0] wsec(logic [AW-1:0] a);
    logic [255:0] s;
    for (int i = 0; i < 8; i++) s[32*i +: 32] = wpat(a, i);
    return s;
  endfunction
  function automatic logic [255:0] rsec(logic [AW-1:0] a);
    logic [255:0] s;
    for (int i = 0; i < 8; i++) s[32*i +: 32] = rpat(a, i);
    return s;
  endfunction

  // bus model
  assign bus_gnt   = bus_req && gnt_en;
  assign bus_rdata = rpat(bus_addr, int'(bcnt));
  always @(posedge clk) begin
    if (!rst_n)        bcnt <= '0;
    else if (bus_beat) bcnt <= bcnt + 3'd1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_burst(input bit wr, input logic [AW-1:0] a);
    expq.push_back({wr, a});
  endtask

  // monitor: compares each finished burst with the head of the scoreboard
  int seen = 0;
  bit cur_wr, word_bad, gnt_prev = 0;
  logic [AW-1:0] cur_addr, last_rd;
  always @(negedge clk) if (rst_n) begin
    if (gnt_prev) check(bus_beat, "R5 beat after grant", 64'(bus_beat), 64'd1);
    gnt_prev = bus_req && bus_gnt;
    if (bus_beat) begin
      if (seen == 0) begin cur_wr = bus_write; cur_addr = bus_addr; word_bad = 0; end
      if (bus_write != cur_wr || bus_addr != cur_addr) word_bad = 1;
      if (cur_wr && bus_wdata != wpat(cur_addr, seen)) word_bad = 1;
      seen++;
      if (seen == 8) begin
        logic [AW:0] e;
        seen = 0;
        bursts++;
        check(!word_bad, cur_wr ? "R3 write beats" : "R5 burst fields", 64'(word_bad), 64'd0);
        if (expq.size() == 0) check(0, "R4 unexpected burst", 64'({cur_wr, cur_addr}), 64'd0);
        else begin
          e = expq.pop_front();
          check(e == {cur_wr, cur_addr}, "R6/R7/R8/R10 issue order", 64'({cur_wr, cur_addr}), 64'(e));
        end
        if (!cur_wr) last_rd = cur_addr;
      end
    end else if (seen != 0) begin
      check(0, "R5 burst length", 64'(seen), 64'd8);
      seen = 0;
    end
    if (rsp_valid) begin
      rsps++;
      check(rsp_addr == last_rd, "R2 rsp addr", 64'(rsp_addr), 64'(last_rd));
      check(rsp_data == rsec(rsp_addr), "R2 rsp data", rsp_data[63:0], rsec(rsp_addr)[63:0]);
    end
  end

  task automatic push_rd(input logic [AW-1:0] a);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0;
  endtask
  task automatic push_wr(input logic [AW-1:0] a);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = wsec(a);
    @(negedge clk); wr_valid = 0;
  endtask
  task automatic offer_rd(input logic [AW-1:0] a);   // one cycle, regardless of ready
    @(negedge clk); rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0;
  endtask
  task automatic offer_wr(input logic [AW-1:0] a);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = wsec(a);
    @(negedge clk); wr_valid = 0;
  endtask
  task automatic barrier();
    @(negedge clk); bar_valid = 1;
    @(negedge clk); bar_valid = 0;
  endtask
  task automatic drain();
    gnt_en = 1;
    while (expq.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask
  task automatic block(input logic [AW-1:0] a);      // park one read in the engine
    gnt_en = 0;
    expect_burst(0, a);
    push_rd(a);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(rd_ready && wr_ready && bar_ready, "R1 ready after reset",
          64'({rd_ready, wr_ready, bar_ready}), 64'h7);
    check(!bus_req && !bus_beat && !rsp_valid, "R1 bus idle after reset",
          64'({bus_req, bus_beat, rsp_valid}), 64'h0);

    // R2 single read, R3 single write
    r0 = rsps;
    gnt_en = 1;
    expect_burst(0, 27'h0001234); push_rd(27'h0001234);
    drain();
    check(rsps == r0 + 1, "R2 one response", 64'(rsps - r0), 64'd1);
    expect_burst(1, 27'h0000777); push_wr(27'h0000777);
    drain();

    // R6 read priority; R10 write order
    block(27'h100);
    push_wr(27'h110); push_wr(27'h111); push_rd(27'h120);
    expect_burst(0, 27'h120); expect_burst(1, 27'h110); expect_burst(1, 27'h111);
    drain();

    // R7 address match: read waits behind both writes up to the matching one
    block(27'h200);
    push_wr(27'h240); push_wr(27'h230); push_rd(27'h230);
    expect_burst(1, 27'h240); expect_burst(1, 27'h230); expect_burst(0, 27'h230);
    drain();

    // R8 barrier keeps a younger read behind an older write
    block(27'h300);
    push_wr(27'h350); barrier(); push_rd(27'h360);
    expect_burst(1, 27'h350); expect_burst(0, 27'h360);
    drain();

    // R4 capacity and dropped offers; R10 read order
    b0 = bursts;
    block(27'h400);
    push_rd(27'h401);
    @(negedge clk);
    check(!rd_ready, "R4 read queue full at 2", 64'(rd_ready), 64'd0);
    offer_rd(27'h4FF);
    push_wr(27'h410); push_wr(27'h411); push_wr(27'h412);
    @(negedge clk);
    check(!wr_ready, "R4 write queue full at 3", 64'(wr_ready), 64'd0);
    offer_wr(27'h4FE);
    expect_burst(0, 27'h401);
    expect_burst(1, 27'h410); expect_burst(1, 27'h411); expect_burst(1, 27'h412);
    drain();
    check(bursts == b0 + 5, "R4 dropped offers never issued", 64'(bursts - b0), 64'd5);

    // R9 barrier limit
    block(27'h500);
    repeat (7) barrier();
    @(negedge clk);
    check(!bar_ready, "R9 bar_ready low at 7 open groups", 64'(bar_ready), 64'd0);
    drain();
    check(bar_ready, "R9 bar_ready back after drain", 64'(bar_ready), 64'd1);

    check(expq.size() == 0, "R10 scoreboard empty", 64'(expq.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule